// File: doc/BRIEF.md
# Vectored interrupt request controller

This block gathers up to 64 interrupt request lines and offers the CPU core one prioritised request at a time. The request is given as a trap vector number and a priority level. Each line has a fixed vector, and the line's number sets its priority. No register programs either one.

Every input passes through a two-flop synchroniser, and a rising edge on it sets a pending bit for that line. When the CPU takes an interrupt, it returns the accepted vector number on the acknowledge input. The controller then clears that line's pending bit itself. No line can be masked or disabled on its own. The CPU supplies its current level, and only a request whose level is strictly above that level is presented.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Line i (0 to 63) is reported as vector 64+i. Bit 6 of the vector is 1 and bits 5:0 equal i.
- R2: The reported level is bits 5:2 of the vector, which equals i/4. Lines therefore fall into 16 levels of four lines each.
- R3: Among pending lines, the highest level wins, and within a level the highest vector wins. Because the level grows with the vector, this is the same as the highest pending vector winning.
- R4: The request output is high only when the winning level is strictly greater than `cpu_level`. While it is low, `irq_vector` and `irq_level` read 0. A line at level 0 is never presented.
- R5: With no acknowledge and an unchanged `cpu_level`, the presented vector stays the same. It is replaced only when a line with a higher vector becomes pending.
- R6: An acknowledge clears the pending bit of the acknowledged line only, on the clock edge where `ack_valid` is high. An acknowledge of a vector below 64, or of a line that is not pending, has no effect.
- R7: A line is sampled through a two-flop synchroniser and then edge-detected. A rising input is presented on the third clock edge after it changes, not earlier. An input that stays high sets its pending bit only once.
- R8: A new edge on a line in the same cycle as that line's acknowledge leaves the line pending.
- R9: Reset clears every pending bit and drives `irq_req`, `irq_vector` and `irq_level` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines, asynchronous |
| cpu_level | input | 4 | Current CPU interrupt mask level |
| ack_valid | input | 1 | One-cycle acknowledge strobe from the CPU |
| ack_vector | input | 7 | Vector number being accepted |
| irq_req | output | 1 | An interrupt above the mask level is offered |
| irq_vector | output | 7 | Vector number of the offered interrupt |
| irq_level | output | 4 | Priority level of the offered interrupt |

## Verification
A rising input becomes visible at the outputs after three clock edges: two synchroniser flops and the pending register. The bench checks one edge early, to see nothing yet, and then exactly at the third edge. An acknowledge takes effect on the one edge where it is held, and `cpu_level` acts within the same cycle because the output path is combinational. The bench drives on the falling edge and samples on a later falling edge, counted from these latencies. The race between a new edge and an acknowledge is set up so that the edge-detect cycle lands on the edge where the acknowledge is sampled.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int N_LINES  = 64,
  parameter int VEC_BASE = 64,
  parameter int LVL_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [63:0]        irq_in,
  input  logic [LVL_W-1:0]   cpu_level,
  input  logic               ack_valid,
  input  logic [6:0]         ack_vector,
  output logic               irq_req,
  output logic [6:0]         irq_vector,
  output logic [LVL_W-1:0]   irq_level
);
  localparam int VEC_W = 7;
  localparam int IDX_W = $clog2(N_LINES);

  logic [N_LINES-1:0] sync1, sync2, prev, pend, edge_det, ack_mask;
  logic [VEC_W-1:0]   ack_off, win_vec;
  logic [IDX_W-1:0]   win_idx;
  logic               any_pend;
  logic [LVL_W-1:0]   win_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= irq_in[N_LINES-1:0];
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign edge_det = sync2 & ~prev;
  assign ack_off  = ack_vector - VEC_W'(VEC_BASE);

  always_comb begin
    ack_mask = '0;
    if (ack_valid && ack_vector >= VEC_W'(VEC_BASE) && ack_off < VEC_W'(N_LINES))
      ack_mask[ack_off[IDX_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~ack_mask) | edge_det;
  end

  always_comb begin
    win_idx  = '0;
    any_pend = 1'b0;
    for (int i = 0; i < N_LINES; i++) begin
      if (pend[i]) begin
        win_idx  = IDX_W'(i);
        any_pend = 1'b1;
      end
    end
  end

  assign win_vec    = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
  assign win_lvl    = win_vec[LVL_W+1:2];
  assign irq_req    = any_pend && (win_lvl > cpu_level);
  assign irq_vector = irq_req ? win_vec : '0;
  assign irq_level  = irq_req ? win_lvl : '0;
endmodule

module vec_irq_ctrl_chk #(
  parameter int N_LINES = 64,
  parameter int LVL_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LVL_W-1:0]   cpu_level,
  input logic               ack_valid,
  input logic [6:0]         ack_vector,
  input logic               irq_req,
  input logic [6:0]         irq_vector,
  input logic [LVL_W-1:0]   irq_level,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] edge_det
);
  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vector[6]);

  p_above_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_level > cpu_level);

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vector == 7'd0 && irq_level == '0));

  p_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ack_valid) |=> (!$stable(cpu_level) || (irq_req && irq_vector >= $past(irq_vector))));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_vector[6] && !edge_det[ack_vector[5:0]]) |=> !pend[$past(ack_vector[5:0])]);

  p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det != '0) |=> ((pend & $past(edge_det)) == $past(edge_det)));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_level(cpu_level), .ack_valid(ack_valid),
  .ack_vector(ack_vector), .irq_req(irq_req), .irq_vector(irq_vector),
  .irq_level(irq_level), .pend(pend), .edge_det(edge_det)
);

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic [3:0]  cpu_level = '0;
  logic        ack_valid = 1'b0;
  logic [6:0]  ack_vector = '0;
  logic        irq_req;
  logic [6:0]  irq_vector;
  logic [3:0]  irq_level;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  vec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cpu_level(cpu_level),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .irq_req(irq_req),
    .irq_vector(irq_vector), .irq_level(irq_level)
  );

  always #10 clk = ~clk;

  task automatic expect_out(string req, logic r, logic [6:0] v, logic [3:0] l);
    checks++;
    if (irq_req !== r || irq_vector !== v || irq_level !== l) begin
      failures++;
      $display("FAIL %s: got req=%0b vec=%0d lvl=%0d, expected req=%0b vec=%0d lvl=%0d",
               req, irq_req, irq_vector, irq_level, r, v, l);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack(logic [6:0] v);
    ack_valid  = 1'b1;
    ack_vector = v;
    edges(1);
    ack_valid  = 1'b0;
  endtask

  task automatic raise(int line);
    irq_in[line] = 1'b1;
    edges(3);
  endtask

  task automatic t_reset;
    expect_out("R9 reset state", 1'b0, 7'd0, 4'd0);
  endtask

  task automatic t_single;
    cpu_level = 4'd0;
    irq_in[10] = 1'b1;
    edges(2);
    expect_out("R7 not yet after two edges", 1'b0, 7'd0, 4'd0);
    edges(1);
    expect_out("R1 R2 line 10 presented", 1'b1, 7'd74, 4'd2);
    ack(7'd74);
    expect_out("R6 ack clears line 10", 1'b0, 7'd0, 4'd0);
    edges(5);
    expect_out("R7 held level does not re-pend", 1'b0, 7'd0, 4'd0);
    irq_in[10] = 1'b0;
    edges(3);
  endtask

  task automatic t_priority;
    irq_in[5] = 1'b1; irq_in[6] = 1'b1; irq_in[20] = 1'b1;
    edges(3);
    expect_out("R3 highest level wins", 1'b1, 7'd84, 4'd5);
    ack(7'd84);
    expect_out("R3 highest vector within level 1", 1'b1, 7'd70, 4'd1);
    ack(7'd70);
    expect_out("R6 only line 6 cleared, line 5 next", 1'b1, 7'd69, 4'd1);
    ack(7'd69);
    expect_out("R6 all cleared", 1'b0, 7'd0, 4'd0);
    irq_in = '0;
    edges(3);
  endtask

  task automatic t_mask;
    cpu_level = 4'd5;
    raise(20);
    expect_out("R4 level equal to mask not presented", 1'b0, 7'd0, 4'd0);
    cpu_level = 4'd4;
    edges(1);
    expect_out("R4 mask lowered presents", 1'b1, 7'd84, 4'd5);
    cpu_level = 4'd5;
    ack(7'd84);
    cpu_level = 4'd0;
    edges(1);
    expect_out("R6 ack while masked cleared line", 1'b0, 7'd0, 4'd0);
    cpu_level = 4'd14;
    raise(63);
    expect_out("R1 R2 top line above mask 14", 1'b1, 7'd127, 4'd15);
    cpu_level = 4'd15;
    edges(1);
    expect_out("R4 mask 15 blocks all", 1'b0, 7'd0, 4'd0);
    ack(7'd127);
    cpu_level = 4'd0;
    irq_in = '0;
    edges(3);
    expect_out("R6 top line cleared", 1'b0, 7'd0, 4'd0);
  endtask

  task automatic t_stable;
    raise(8);
    expect_out("R5 line 8 presented", 1'b1, 7'd72, 4'd2);
    edges(4);
    expect_out("R5 stable without ack", 1'b1, 7'd72, 4'd2);
    raise(9);
    expect_out("R5 higher line preempts", 1'b1, 7'd73, 4'd2);
    raise(3);
    expect_out("R5 lower line does not disturb", 1'b1, 7'd73, 4'd2);
    ack(7'd73);
    expect_out("R6 back to line 8", 1'b1, 7'd72, 4'd2);
    ack(7'd72);
    expect_out("R4 level 0 line never presented", 1'b0, 7'd0, 4'd0);
    ack(7'd67);
    irq_in = '0;
    edges(3);
  endtask

  task automatic t_bad_ack;
    raise(30);
    expect_out("R1 line 30 presented", 1'b1, 7'd94, 4'd7);
    ack(7'd30);
    expect_out("R6 ack below 64 ignored", 1'b1, 7'd94, 4'd7);
    ack(7'd95);
    expect_out("R6 ack of non-pending line ignored", 1'b1, 7'd94, 4'd7);
    ack(7'd94);
    expect_out("R6 line 30 cleared", 1'b0, 7'd0, 4'd0);
    irq_in = '0;
    edges(3);
  endtask

  task automatic t_ack_race;
    raise(40);
    expect_out("R1 line 40 presented", 1'b1, 7'd104, 4'd10);
    irq_in[40] = 1'b0;
    edges(4);
    irq_in[40] = 1'b1;
    edges(2);
    ack(7'd104);
    expect_out("R8 edge with ack keeps pending", 1'b1, 7'd104, 4'd10);
    ack(7'd104);
    expect_out("R8 later ack clears", 1'b0, 7'd0, 4'd0);
    irq_in = '0;
    edges(3);
  endtask

  task automatic t_reset_mid;
    raise(50);
    rst_n = 1'b0;
    edges(1);
    expect_out("R9 reset clears pending", 1'b0, 7'd0, 4'd0);
    irq_in = '0;
    rst_n = 1'b1;
    edges(4);
    expect_out("R9 stays clear after reset", 1'b0, 7'd0, 4'd0);
  endtask

  initial begin
    edges(2);
    t_reset;
    rst_n = 1'b1;
    edges(2);
    t_single;
    t_priority;
    t_mask;
    t_stable;
    t_bad_ack;
    t_ack_race;
    t_reset_mid;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule